// File: doc/BRIEF.md
# Keyed Configuration Port with Banked GPIO

This block is a byte-wide configuration port that a host reaches through two adjacent I/O addresses. The lower address selects a register index and the upper address moves data to or from the indexed register. The port stays closed after reset. While it is closed, data-port writes have no effect and every read returns 0xFF. Writing the opening key to the index port twice in a row opens it. A separate closing key shuts it again.

Once the port is open, index 0x07 picks a logical device, and that choice decides which registers answer at the per-device indices. Two indices that do not depend on the device return a fixed 16-bit chip identifier. The GPIO device holds an enable register and, for each 8-pin bank, a direction register and a data register. The output-mode device holds one mode register per bank, which selects open-drain or push-pull drive for each pin. The block drives each pad with a value and an output enable. Reading a data register returns the level seen on the pads.

Top module: `cfg_port_gpio`

## Requirements
- R1: The index port sits at BASE_ADDR (default 0x2E) and the data port at BASE_ADDR+1. A bus access to any other address changes no state and reads 0xFF.
- R2: The port opens only after two consecutive index-port writes of 0x87. Any other index-port write while the port is closed restarts the key detection.
- R3: An index-port write of 0xAA while the port is open closes it.
- R4: While the port is closed, data-port writes change no register, and reads of the index port or the data port return 0xFF.
- R5: Index 0x07 is the logical-device select. A data write there stores the device number, and a data read returns it. While open, an index-port read returns the current index.
- R6: Indices 0x20 and 0x21 return 0x10 and 0x61 for every selected device. Writes to them are ignored.
- R7: In device 0x07, index 0x30 is the bank enable: bit b enables bank b. Bits above the bank count read 0. A disabled bank drives no pad.
- R8: In device 0x07, bank b has its direction register at 0xE0+4b and its data register at 0xE1+4b. A direction bit of 1 is an input and 0 is an output. A data write loads the bank's output latch, and a data read returns the pad levels.
- R9: In device 0x0F, bank b has its mode register at 0xE0+b. A mode bit of 1 selects open-drain and 0 selects push-pull.
- R10: A pin drives only when its bank is enabled and its direction bit is 0. In push-pull mode the output enable is 1 and the pad value is the latch bit. In open-drain mode a latch bit of 0 drives the pad low and a 1 releases it.
- R11: After reset the port is closed, every direction bit is 1, and the latches, the mode bits, the enables, the device select and the index are all 0.
- R12: Index 0xE0 reaches the direction register only in device 0x07 and the mode register only in device 0x0F. In any other device, writes there are ignored and reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | ADDR_W | Bus I/O address |
| io_wr_i | input | 1 | Bus write strobe, one cycle per access |
| io_rd_i | input | 1 | Bus read strobe |
| io_wdata_i | input | 8 | Bus write data |
| io_rdata_o | output | 8 | Bus read data, valid in the cycle of io_rd_i |
| pad_i | input | NUM_BANKS*8 | Sensed pad levels |
| pad_o | output | NUM_BANKS*8 | Pad output values |
| pad_oe_o | output | NUM_BANKS*8 | Pad output enables |

## Verification
Assertions check the key sequence on every cycle: the port opens only right after a key write, a wrong index write while closed never opens it, and the closing key always shuts it. They also check that the registers hold still while the port is closed, that closed reads return 0xFF, and that the chip identifier stays fixed. At the pads, they check that input pins and disabled banks never drive, and that an open-drain pin never drives high. Only the bench scenarios show the register decode: banking by device, direction and data addressing per bank, enable masking, pad levels read back through the data register, and the exact pad values in each drive mode.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned BANK_PINS = 8;

  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ID_HI = 8'h20;
  localparam logic [7:0] IDX_ID_LO = 8'h21;
  localparam logic [7:0] IDX_EN    = 8'h30;

  localparam logic [7:0] LDN_GPIO  = 8'h07;
  localparam logic [7:0] LDN_MODE  = 8'h0F;

  localparam logic [15:0] CHIP_ID  = 16'h1061;

  typedef enum logic [1:0] {
    ST_LOCKED,
    ST_ARMED,
    ST_OPEN
  } key_state_e;

  function automatic logic [7:0] dir_idx(input int b);
    return 8'hE0 + 8'(b * 4);
  endfunction

  function automatic logic [7:0] dat_idx(input int b);
    return 8'hE1 + 8'(b * 4);
  endfunction

  function automatic logic [7:0] mode_idx(input int b);
    return 8'hE0 + 8'(b);
  endfunction
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        ST_LOCKED: state_d = (wdata_i == KEY_OPEN) ? ST_ARMED : ST_LOCKED;
        ST_ARMED:  state_d = (wdata_i == KEY_OPEN) ? ST_OPEN  : ST_LOCKED;
        ST_OPEN:   state_d = (wdata_i == KEY_CLOSE) ? ST_LOCKED : ST_OPEN;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == ST_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(idx_wr_i && wdata_i == KEY_OPEN)); // R2
  AST_BAD_KEY_STAYS_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && idx_wr_i && wdata_i != KEY_OPEN) |=> !open_o); // R2
  AST_CLOSE_KEY_SHUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == KEY_CLOSE) |=> !open_o); // R3
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned PADS = NUM_BANKS * BANK_PINS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 open_i,
  input  logic                 idx_wr_i,
  input  logic                 dat_wr_i,
  input  logic                 idx_rd_i,
  input  logic                 dat_rd_i,
  input  logic [7:0]           wdata_i,
  input  logic [PADS-1:0]      bank_dir_i,
  input  logic [PADS-1:0]      bank_mode_i,
  input  logic [PADS-1:0]      pad_lvl_i,
  output logic [7:0]           rdata_o,
  output logic [NUM_BANKS-1:0] en_o,
  output logic [NUM_BANKS-1:0] dir_we_o,
  output logic [NUM_BANKS-1:0] lat_we_o,
  output logic [NUM_BANKS-1:0] mode_we_o
);
  logic [7:0]           index_q, ldn_q;
  logic [NUM_BANKS-1:0] en_q;
  logic                 wr_ok;

  assign wr_ok = open_i && dat_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ldn_q   <= '0;
      en_q    <= '0;
    end else begin
      if (open_i && idx_wr_i && wdata_i != KEY_CLOSE) index_q <= wdata_i;
      if (wr_ok && index_q == IDX_LDN) ldn_q <= wdata_i;
      if (wr_ok && ldn_q == LDN_GPIO && index_q == IDX_EN)
        en_q <= wdata_i[NUM_BANKS-1:0];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
    assign dir_we_o[b]  = wr_ok && ldn_q == LDN_GPIO && index_q == dir_idx(b);
    assign lat_we_o[b]  = wr_ok && ldn_q == LDN_GPIO && index_q == dat_idx(b);
    assign mode_we_o[b] = wr_ok && ldn_q == LDN_MODE && index_q == mode_idx(b);
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (open_i && idx_rd_i) begin
      rdata_o = index_q;
    end else if (open_i && dat_rd_i) begin
      rdata_o = 8'h00;
      if (index_q == IDX_LDN)        rdata_o = ldn_q;
      else if (index_q == IDX_ID_HI) rdata_o = CHIP_ID[15:8];
      else if (index_q == IDX_ID_LO) rdata_o = CHIP_ID[7:0];
      else if (ldn_q == LDN_GPIO) begin
        if (index_q == IDX_EN) rdata_o = 8'(en_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (index_q == dir_idx(b)) rdata_o = bank_dir_i[b*BANK_PINS +: BANK_PINS];
          if (index_q == dat_idx(b)) rdata_o = pad_lvl_i[b*BANK_PINS +: BANK_PINS];
        end
      end else if (ldn_q == LDN_MODE) begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (index_q == mode_idx(b)) rdata_o = bank_mode_i[b*BANK_PINS +: BANK_PINS];
      end
    end
  end

  assign en_o = en_q;

  AST_LOCKED_HOLDS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> ($stable(ldn_q) && $stable(en_q) && $stable(index_q))); // R4
  AST_LOCKED_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |-> (dir_we_o == '0 && lat_we_o == '0 && mode_we_o == '0)); // R4
  AST_LOCKED_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_i && (idx_rd_i || dat_rd_i)) |-> rdata_o == 8'hFF); // R4
  AST_ID_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && dat_rd_i && index_q == IDX_ID_LO) |-> rdata_o == CHIP_ID[7:0]); // R6
endmodule

// File: rtl/cfg_gpio_bank.sv
module cfg_gpio_bank
  import cfg_port_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 dir_we_i,
  input  logic                 lat_we_i,
  input  logic                 mode_we_i,
  input  logic [7:0]           wdata_i,
  output logic [BANK_PINS-1:0] dir_o,
  output logic [BANK_PINS-1:0] mode_o,
  output logic [BANK_PINS-1:0] pad_o,
  output logic [BANK_PINS-1:0] pad_oe_o
);
  logic [BANK_PINS-1:0] dir_q, lat_q, mode_q, drv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      lat_q  <= '0;
      mode_q <= '0;
    end else begin
      if (dir_we_i)  dir_q  <= wdata_i[BANK_PINS-1:0];
      if (lat_we_i)  lat_q  <= wdata_i[BANK_PINS-1:0];
      if (mode_we_i) mode_q <= wdata_i[BANK_PINS-1:0];
    end
  end

  // open-drain: latch 1 releases, latch 0 pulls low
  assign drv      = {BANK_PINS{en_i}} & ~dir_q;
  assign pad_oe_o = drv & (~mode_q | ~lat_q);
  assign pad_o    = drv & ~mode_q & lat_q;
  assign dir_o    = dir_q;
  assign mode_o   = mode_q;

  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & dir_q) == '0); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> pad_oe_o == '0); // R7
  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & pad_oe_o & mode_q) == '0); // R10
endmodule

// File: rtl/cfg_port_gpio.sv
module cfg_port_gpio
  import cfg_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned PADS     = NUM_BANKS * BANK_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic [PADS-1:0]   pad_i,
  output logic [PADS-1:0]   pad_o,
  output logic [PADS-1:0]   pad_oe_o
);
  logic                 idx_sel, dat_sel, cfg_open;
  logic [NUM_BANKS-1:0] en, dir_we, lat_we, mode_we;
  logic [PADS-1:0]      dir_all, mode_all;

  assign idx_sel = (io_addr_i == ADDR_W'(BASE_ADDR));
  assign dat_sel = (io_addr_i == ADDR_W'(BASE_ADDR + 16'd1));

  cfg_key_fsm u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (io_wr_i && idx_sel),
    .wdata_i  (io_wdata_i),
    .open_o   (cfg_open)
  );

  cfg_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (cfg_open),
    .idx_wr_i    (io_wr_i && idx_sel),
    .dat_wr_i    (io_wr_i && dat_sel),
    .idx_rd_i    (io_rd_i && idx_sel),
    .dat_rd_i    (io_rd_i && dat_sel),
    .wdata_i     (io_wdata_i),
    .bank_dir_i  (dir_all),
    .bank_mode_i (mode_all),
    .pad_lvl_i   (pad_i),
    .rdata_o     (io_rdata_o),
    .en_o        (en),
    .dir_we_o    (dir_we),
    .lat_we_o    (lat_we),
    .mode_we_o   (mode_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    cfg_gpio_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en[b]),
      .dir_we_i  (dir_we[b]),
      .lat_we_i  (lat_we[b]),
      .mode_we_i (mode_we[b]),
      .wdata_i   (io_wdata_i),
      .dir_o     (dir_all[b*BANK_PINS +: BANK_PINS]),
      .mode_o    (mode_all[b*BANK_PINS +: BANK_PINS]),
      .pad_o     (pad_o[b*BANK_PINS +: BANK_PINS]),
      .pad_oe_o  (pad_oe_o[b*BANK_PINS +: BANK_PINS])
    );
  end

  AST_FOREIGN_ADDR_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !idx_sel && !dat_sel) |-> io_rdata_o == 8'hFF); // R1
endmodule

// File: tb/tb_cfg_port_gpio.sv
module tb_cfg_port_gpio;
  localparam logic [15:0] BASE = 16'h002E;
  localparam logic [15:0] IDXP = BASE;
  localparam logic [15:0] DATP = BASE + 16'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic [15:0] pad_in, pad_out, pad_oe;
  logic [15:0] ext = 16'hC33C;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  cfg_port_gpio dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    bus_wr(IDXP, idx);
    bus_wr(DATP, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    bus_wr(IDXP, idx);
    bus_rd(DATP, d);
  endtask

  task automatic unlock();
    bus_wr(IDXP, 8'h87);
    bus_wr(IDXP, 8'h87);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(DATP, d);   chk(16'(d), 16'h00FF, "R11 closed after reset");
    bus_rd(IDXP, d);   chk(16'(d), 16'h00FF, "R4 index read while closed");
    chk(pad_oe, 16'h0000, "R11 no pad driven after reset");
  endtask

  task automatic t_foreign_addr();
    logic [7:0] d;
    bus_wr(BASE + 16'd2, 8'h87);
    bus_wr(BASE + 16'd2, 8'h87);
    bus_rd(DATP, d);   chk(16'(d), 16'h00FF, "R1 key at foreign address ignored");
    bus_rd(BASE + 16'd4, d); chk(16'(d), 16'h00FF, "R1 foreign read");
  endtask

  task automatic t_unlock_and_select();
    logic [7:0] d;
    unlock();
    reg_rd(8'h07, d);  chk(16'(d), 16'h0000, "R11 device select reset");
    bus_rd(IDXP, d);   chk(16'(d), 16'h0007, "R5 index read back");
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h07, d);  chk(16'(d), 16'h0007, "R5 device select read back");
  endtask

  task automatic t_chip_id();
    logic [7:0] d;
    reg_rd(8'h20, d);  chk(16'(d), 16'h0010, "R6 id high");
    reg_rd(8'h21, d);  chk(16'(d), 16'h0061, "R6 id low");
    reg_wr(8'h20, 8'h55);
    reg_rd(8'h20, d);  chk(16'(d), 16'h0010, "R6 id write ignored");
  endtask

  task automatic t_gpio_drive();
    logic [7:0] d;
    reg_rd(8'h30, d);  chk(16'(d), 16'h0000, "R11 enable reset");
    reg_rd(8'hE0, d);  chk(16'(d), 16'h00FF, "R11 direction reset");
    reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, d);  chk(16'(d), 16'h0003, "R7 enable upper bits zero");
    reg_wr(8'hE1, 8'hA5);
    reg_wr(8'hE0, 8'h0F);
    chk(pad_oe[7:0], 16'h00F0, "R10 bank0 push-pull enables");
    chk(pad_out[7:0], 16'h00A0, "R10 bank0 push-pull values");
    reg_rd(8'hE1, d);  chk(16'(d), 16'h00AC, "R8 bank0 level read");
    reg_wr(8'hE4, 8'h00);
    reg_wr(8'hE5, 8'h5A);
    chk(pad_oe[15:8], 16'h00FF, "R8 bank1 all outputs");
    chk(pad_out[15:8], 16'h005A, "R8 bank1 latch drives pads");
    reg_rd(8'hE5, d);  chk(16'(d), 16'h005A, "R8 bank1 level read");
  endtask

  task automatic t_disable();
    reg_wr(8'h30, 8'h01);
    chk(pad_oe[15:8], 16'h0000, "R7 disabled bank quiet");
    chk(pad_oe[7:0], 16'h00F0, "R7 enabled bank still drives");
  endtask

  task automatic t_mode_and_banking();
    logic [7:0] d;
    reg_wr(8'h07, 8'h0F);
    reg_wr(8'hE0, 8'hF0);
    reg_rd(8'hE0, d);  chk(16'(d), 16'h00F0, "R9 mode read back");
    chk(pad_oe[7:0], 16'h0050, "R10 open-drain enables");
    chk(pad_out[7:0], 16'h0000, "R10 open-drain drives low only");
    reg_wr(8'h07, 8'h03);
    reg_wr(8'hE0, 8'h00);
    reg_rd(8'hE0, d);  chk(16'(d), 16'h0000, "R12 other device reads zero");
    reg_wr(8'h07, 8'h07);
    reg_rd(8'hE0, d);  chk(16'(d), 16'h000F, "R12 direction kept");
    reg_wr(8'h07, 8'h0F);
    reg_rd(8'hE0, d);  chk(16'(d), 16'h00F0, "R12 mode kept");
    reg_wr(8'h07, 8'h07);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    logic [15:0] oe_before;
    bus_wr(IDXP, 8'hE0);
    oe_before = pad_oe;
    bus_wr(IDXP, 8'hAA);
    bus_rd(DATP, d);   chk(16'(d), 16'h00FF, "R3 closed after close key");
    bus_wr(DATP, 8'hFF);
    chk(pad_oe, oe_before, "R4 locked write no effect on pads");
    unlock();
    reg_rd(8'hE0, d);  chk(16'(d), 16'h000F, "R4 direction unchanged by locked write");
  endtask

  task automatic t_bad_sequence();
    logic [7:0] d;
    bus_wr(IDXP, 8'hAA);
    bus_wr(IDXP, 8'h87);
    bus_wr(IDXP, 8'h12);
    bus_wr(IDXP, 8'h87);
    bus_rd(DATP, d);   chk(16'(d), 16'h00FF, "R2 broken key stays closed");
    bus_wr(IDXP, 8'h87);
    bus_rd(IDXP, d);   chk(16'(d), 16'h00E0, "R2 open after two keys");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_foreign_addr();
    t_unlock_and_select();
    t_chip_id();
    t_gpio_drive();
    t_disable();
    t_mode_and_banking();
    t_lock();
    t_bad_sequence();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule